// File: doc/BRIEF.md
# Playback Test Waveform Generator

The generator produces synthetic ADC sample streams, so that trigger and readout logic can be exercised without detector signals. It has two channel groups, scintillator and calorimeter, with eight channels each. Every group has its own pedestal, pulse start, pulse length and amplitude word. Each accepted trigger plays out one record of 32 samples, one per clock. In every sample each channel carries its group pedestal. Inside the pulse window it also carries a rectangular pulse whose height is that channel's 4-bit amplitude code times 100 ADC counts.

A write to the mode input arms the generator for a fixed number of records, from 0 to 9. Each record uses up one of them. When the budget reaches zero, triggers have no effect until the mode is written again. The generator flags a configuration whose pulse window does not fit in the record, and also a stored mode above 9, and it refuses to play while the flag is raised. The configuration in force at the moment a trigger is accepted is captured for the whole record.

Top module: `pbgen`

## Requirements
- R1: After reset, `samp_valid` is 0, every sample reads 0, `cfg_err` is 0 with all-zero configuration inputs, and the record budget is 0, so triggers are ignored until a mode write.
- R2: An accepted trigger, sampled at clock edge E, makes `samp_valid` high for exactly 32 consecutive cycles, starting in the cycle after E. Sample index k (0..31) is presented in the k-th of those cycles.
- R3: For scintillator channel c (0..7), the sample at index k is `sc_ped + 100*A` when `sc_delay <= k < sc_delay + sc_width`, and `sc_ped` otherwise. A is `sc_amps[4c+3:4c]`: channels 0-3 (left side) sit in the low four nibbles and channels 4-7 (right side) in the high four. The channel's sample occupies `sc_samp[12c+11:12c]`.
- R4: Calorimeter channels follow the rule of R3, using `cal_ped`, `cal_delay`, `cal_width` and `cal_amps`, with the output on `cal_samp`.
- R5: A sample whose pedestal plus amplitude exceeds 4095 reads 4095. It does not wrap.
- R6: Pedestal, width, delay and amplitude words are captured when a trigger is accepted. Changing them during a record does not alter that record.
- R7: A trigger that arrives while a record is playing, including during its last sample, is ignored and does not use up the budget.
- R8: A mode write loads both the stored mode and the remaining budget with `mode_in`. Each accepted record decrements the budget. A budget of 0, including the one left by writing mode 0, makes triggers ignored. A trigger in the same cycle as a mode write is ignored.
- R9: `cfg_err` is high, combinationally, whenever `sc_width + sc_delay >= 32`, `cal_width + cal_delay >= 32`, or the stored mode exceeds 9. While it is high, triggers are ignored and do not use up the budget.
- R10: Whenever `samp_valid` is low, every bit of `sc_samp` and `cal_samp` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Load strobe for `mode_in` |
| mode_in | input | 4 | Number of records to play (0 disables) |
| trig | input | 1 | Trigger strobe |
| sc_ped | input | 12 | Scintillator pedestal |
| sc_width | input | 5 | Scintillator pulse length in samples |
| sc_delay | input | 5 | Scintillator pulse start index |
| sc_amps | input | 32 | Scintillator amplitude codes, one nibble per channel |
| cal_ped | input | 12 | Calorimeter pedestal |
| cal_width | input | 5 | Calorimeter pulse length in samples |
| cal_delay | input | 5 | Calorimeter pulse start index |
| cal_amps | input | 32 | Calorimeter amplitude codes, one nibble per channel |
| samp_valid | output | 1 | High while a record is being played |
| sc_samp | output | 96 | Eight 12-bit scintillator samples |
| cal_samp | output | 96 | Eight 12-bit calorimeter samples |
| cfg_err | output | 1 | Configuration or mode out of range |

## Verification
The assertions watch the record framing on every cycle: a valid run never outlasts 32 samples and always ends at exactly 32, and samples are zero outside a run. They also check every run start: it is preceded by a trigger with no mode write and no error flag, and it stays within the number of records granted by the last mode write. The sample values themselves cannot be checked by the assertions. The same holds for the pulse window placement, the saturation at full scale, and the capture of parameters at trigger time. Only the bench's scenarios show these, by comparing every sample of every channel against a behavioural model while the configuration is changed around and during records.

// File: rtl/pbgen.sv
module pbgen #(
  parameter int NCH      = 8,
  parameter int SAMP_W   = 12,
  parameter int REC_LEN  = 32,
  parameter int AMP_STEP = 100,
  parameter int MAX_TRIG = 9,
  parameter int MODE_W   = 4,
  localparam int IDX_W   = $clog2(REC_LEN),
  localparam int AMPS_W  = 4 * NCH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_wr,
  input  logic [MODE_W-1:0]     mode_in,
  input  logic                  trig,
  input  logic [SAMP_W-1:0]     sc_ped,
  input  logic [IDX_W-1:0]      sc_width,
  input  logic [IDX_W-1:0]      sc_delay,
  input  logic [AMPS_W-1:0]     sc_amps,
  input  logic [SAMP_W-1:0]     cal_ped,
  input  logic [IDX_W-1:0]      cal_width,
  input  logic [IDX_W-1:0]      cal_delay,
  input  logic [AMPS_W-1:0]     cal_amps,
  output logic                  samp_valid,
  output logic [NCH*SAMP_W-1:0] sc_samp,
  output logic [NCH*SAMP_W-1:0] cal_samp,
  output logic                  cfg_err
);

  localparam int unsigned MAXC = (1 << SAMP_W) - 1;
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(REC_LEN);

  logic                active;
  logic [IDX_W-1:0]    idx;
  logic [MODE_W-1:0]   mode_q, left;
  logic [SAMP_W-1:0]   sc_ped_q, cal_ped_q;
  logic [IDX_W-1:0]    sc_w_q, sc_d_q, cal_w_q, cal_d_q;
  logic [AMPS_W-1:0]   sc_a_q, cal_a_q;
  logic                accept, sc_on, cal_on;

  function automatic logic bad_win(input logic [IDX_W-1:0] w, input logic [IDX_W-1:0] d);
    return ({1'b0, w} + {1'b0, d}) >= LIMIT;
  endfunction

  function automatic logic in_win(input logic [IDX_W-1:0] i, input logic [IDX_W-1:0] d,
                                  input logic [IDX_W-1:0] w);
    logic [IDX_W:0] lo, hi;
    lo = {1'b0, d};
    hi = lo + {1'b0, w};
    return ({1'b0, i} >= lo) && ({1'b0, i} < hi);
  endfunction

  function automatic logic [SAMP_W-1:0] shape(input logic [SAMP_W-1:0] ped,
                                               input logic [3:0] nib, input logic on);
    logic [31:0] s;
    s = 32'(ped) + (on ? 32'(nib) * 32'(AMP_STEP) : 32'd0);
    return (s > 32'(MAXC)) ? SAMP_W'(MAXC) : s[SAMP_W-1:0];
  endfunction

  assign cfg_err = bad_win(sc_width, sc_delay) | bad_win(cal_width, cal_delay)
                 | (32'(mode_q) > 32'(MAX_TRIG));
  assign accept  = trig & ~active & ~mode_wr & ~cfg_err & (left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (accept) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (active) begin
      if (idx == IDX_W'(REC_LEN - 1)) active <= 1'b0;
      else                            idx    <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      left   <= '0;
    end else if (mode_wr) begin
      mode_q <= mode_in;
      left   <= mode_in;
    end else if (accept) begin
      left   <= left - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_ped_q  <= '0; sc_w_q  <= '0; sc_d_q  <= '0; sc_a_q  <= '0;
      cal_ped_q <= '0; cal_w_q <= '0; cal_d_q <= '0; cal_a_q <= '0;
    end else if (accept) begin
      sc_ped_q  <= sc_ped;  sc_w_q  <= sc_width;  sc_d_q  <= sc_delay;  sc_a_q  <= sc_amps;
      cal_ped_q <= cal_ped; cal_w_q <= cal_width; cal_d_q <= cal_delay; cal_a_q <= cal_amps;
    end
  end

  assign samp_valid = active;
  assign sc_on      = in_win(idx, sc_d_q, sc_w_q);
  assign cal_on     = in_win(idx, cal_d_q, cal_w_q);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign sc_samp[c*SAMP_W +: SAMP_W]  = active ? shape(sc_ped_q,  sc_a_q[4*c +: 4],  sc_on)  : '0;
    assign cal_samp[c*SAMP_W +: SAMP_W] = active ? shape(cal_ped_q, cal_a_q[4*c +: 4], cal_on) : '0;
  end

endmodule

// File: rtl/pbgen_chk.sv
module pbgen_chk #(
  parameter int NCH     = 8,
  parameter int SAMP_W  = 12,
  parameter int REC_LEN = 32,
  parameter int MODE_W  = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  mode_wr,
  input logic [MODE_W-1:0]     mode_in,
  input logic                  trig,
  input logic                  samp_valid,
  input logic [NCH*SAMP_W-1:0] sc_samp,
  input logic [NCH*SAMP_W-1:0] cal_samp,
  input logic                  cfg_err
);

  localparam int RUN_W = $clog2(REC_LEN) + 2;

  logic [RUN_W-1:0]  run;
  logic              vld_q;
  logic [MODE_W:0]   started;
  logic [MODE_W-1:0] lim;
  logic              start_now;

  assign start_now = samp_valid & ~vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= '0;
      vld_q   <= 1'b0;
      started <= '0;
      lim     <= '0;
    end else begin
      run   <= samp_valid ? run + 1'b1 : '0;
      vld_q <= samp_valid;
      if (mode_wr) begin
        lim     <= mode_in;
        started <= '0;
      end else if (start_now) begin
        started <= started + 1'b1;
      end
    end
  end

  a_r2_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    samp_valid |-> run < RUN_W'(REC_LEN));

  a_r2_run_exact: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(samp_valid) |-> run == RUN_W'(REC_LEN));

  a_r8_start_needs_trig: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(samp_valid) |-> ($past(trig) && !$past(mode_wr)));

  a_r9_no_start_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(samp_valid) |-> !$past(cfg_err));

  a_r8_budget: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(samp_valid) |-> started < {1'b0, lim});

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_valid |-> (sc_samp == '0 && cal_samp == '0));

endmodule

bind pbgen pbgen_chk #(.NCH(NCH), .SAMP_W(SAMP_W), .REC_LEN(REC_LEN), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in), .trig(trig),
  .samp_valid(samp_valid), .sc_samp(sc_samp), .cal_samp(cal_samp), .cfg_err(cfg_err)
);

// File: tb/pbgen_tb.sv
`timescale 1ns/1ps
module pbgen_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        mode_wr = 1'b0, trig = 1'b0;
  logic [3:0]  mode_in = '0;
  logic [11:0] sc_ped = '0, cal_ped = '0;
  logic [4:0]  sc_width = '0, sc_delay = '0, cal_width = '0, cal_delay = '0;
  logic [31:0] sc_amps = '0, cal_amps = '0;
  logic        samp_valid, cfg_err;
  logic [95:0] sc_samp, cal_samp;

  int checks = 0, errors = 0, nrec = 0;
  bit prev_v = 1'b0;

  always #2 clk = ~clk;

  pbgen u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in), .trig(trig),
    .sc_ped(sc_ped), .sc_width(sc_width), .sc_delay(sc_delay), .sc_amps(sc_amps),
    .cal_ped(cal_ped), .cal_width(cal_width), .cal_delay(cal_delay), .cal_amps(cal_amps),
    .samp_valid(samp_valid), .sc_samp(sc_samp), .cal_samp(cal_samp), .cfg_err(cfg_err)
  );

  // behavioural reference
  int m_act, m_idx, m_left, m_mode;
  int q_sp, q_sw, q_sd, q_cp, q_cw, q_cd;
  int unsigned q_sa, q_ca;

  function automatic int m_err();
    return (int'(sc_width) + int'(sc_delay) >= 32 || int'(cal_width) + int'(cal_delay) >= 32
            || m_mode > 9) ? 1 : 0;
  endfunction

  function automatic int pix(int ped, int w, int d, int unsigned amps, int ch, int k);
    int v;
    v = ped;
    if (k >= d && k < d + w) v += int'((amps >> (4*ch)) & 15) * 100;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_idx = 0; m_left = 0; m_mode = 0;
      q_sp = 0; q_sw = 0; q_sd = 0; q_cp = 0; q_cw = 0; q_cd = 0; q_sa = 0; q_ca = 0;
    end else begin
      int acc;
      acc = (trig && m_act == 0 && !mode_wr && m_err() == 0 && m_left != 0) ? 1 : 0;
      if (m_act != 0) begin
        if (m_idx == 31) m_act = 0; else m_idx++;
      end
      if (acc != 0) begin
        m_act = 1; m_idx = 0;
        q_sp = sc_ped; q_sw = sc_width; q_sd = sc_delay; q_sa = sc_amps;
        q_cp = cal_ped; q_cw = cal_width; q_cd = cal_delay; q_ca = cal_amps;
      end
      if (mode_wr) begin m_mode = mode_in; m_left = mode_in; end
      else if (acc != 0) m_left--;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 R7 R8 R9 samp_valid", int'(samp_valid), m_act);
      chk("R9 cfg_err", int'(cfg_err), m_err());
      for (int c = 0; c < 8; c++) begin
        chk(m_act != 0 ? "R3 R5 R6 sc sample" : "R10 sc idle", int'(sc_samp[c*12 +: 12]),
            m_act != 0 ? pix(q_sp, q_sw, q_sd, q_sa, c, m_idx) : 0);
        chk(m_act != 0 ? "R4 R5 R6 cal sample" : "R10 cal idle", int'(cal_samp[c*12 +: 12]),
            m_act != 0 ? pix(q_cp, q_cw, q_cd, q_ca, c, m_idx) : 0);
      end
      if (samp_valid && !prev_v) nrec++;
      prev_v = samp_valid;
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic pulse_trig();
    trig = 1'b1; tick(); trig = 1'b0;
  endtask
  task automatic set_mode(input int m);
    mode_in = 4'(m); mode_wr = 1'b1; tick(); mode_wr = 1'b0;
  endtask
  task automatic wait_start();
    do @(negedge clk); while (!samp_valid);
  endtask
  function automatic int sc_ch(int c);  return int'(sc_samp[c*12 +: 12]);  endfunction
  function automatic int cal_ch(int c); return int'(cal_samp[c*12 +: 12]); endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", int'(samp_valid), 0);
    chk("R1 err after reset", int'(cfg_err), 0);
    chk("R1 sc zero after reset", int'(sc_samp != '0), 0);
    tick();
    pulse_trig(); tick(5);
    chk("R1 no record without mode write", nrec, 0);

    // R3 R4 nominal record
    sc_ped = 200; sc_width = 5; sc_delay = 1; sc_amps = 32'h000c000e;
    cal_ped = 100; cal_width = 6; cal_delay = 1; cal_amps = 32'h000a000b;
    set_mode(2);
    pulse_trig();
    wait_start();
    chk("R3 sc ch0 idx0 pedestal", sc_ch(0), 200);
    @(negedge clk);
    chk("R3 sc ch0 idx1 pulse", sc_ch(0), 1600);
    chk("R3 sc ch1 zero nibble", sc_ch(1), 200);
    chk("R4 cal ch0 idx1 pulse", cal_ch(0), 1200);
    repeat (4) @(negedge clk);
    chk("R3 sc ch4 idx5 right side", sc_ch(4), 1400);
    @(negedge clk);
    chk("R3 sc ch0 idx6 after pulse", sc_ch(0), 200);
    chk("R4 cal ch0 idx6 last pulse", cal_ch(0), 1200);
    @(negedge clk);
    chk("R4 cal ch4 idx7 after pulse", cal_ch(4), 100);
    tick(40);
    pulse_trig(); tick(40);
    pulse_trig(); tick(40);
    chk("R8 budget of two records", nrec, 3 - 1);

    // R7 triggers mid-record and on the last sample; R6 changes mid-record
    set_mode(3);
    pulse_trig();
    wait_start();
    repeat (10) @(negedge clk);
    trig = 1'b1; sc_ped = 999; cal_amps = 32'hffffffff; sc_delay = 0;
    tick(); trig = 1'b0;
    @(negedge clk);
    chk("R6 sc pedestal held", sc_ch(0), 200);
    chk("R6 cal unchanged", cal_ch(0), 100);
    repeat (20) @(negedge clk);
    chk("R7 still in idx31", int'(samp_valid), 1);
    trig = 1'b1; tick(); trig = 1'b0;
    tick(3);
    chk("R7 triggers while busy ignored", nrec, 3);
    sc_ped = 200; sc_delay = 1; cal_amps = 32'h000a000b;
    pulse_trig(); tick(40);
    pulse_trig(); tick(40);
    chk("R7 budget untouched by busy triggers", nrec, 5);
    pulse_trig(); tick(40);
    chk("R8 budget exhausted", nrec, 5);

    // R5 saturation
    sc_ped = 4000; sc_amps = 32'h0000000f; sc_width = 3; sc_delay = 0;
    cal_ped = 4095; cal_amps = 32'h00000001; cal_width = 1; cal_delay = 0;
    set_mode(1);
    pulse_trig();
    wait_start();
    chk("R5 sc saturates", sc_ch(0), 4095);
    chk("R5 sc unsaturated neighbour", sc_ch(1), 4000);
    chk("R5 cal full scale", cal_ch(0), 4095);
    tick(40);

    // R9 window and mode errors
    sc_ped = 300; sc_width = 20; sc_delay = 12;
    set_mode(2);
    @(negedge clk);
    chk("R9 err on window 32", int'(cfg_err), 1);
    tick(); pulse_trig(); tick(40);
    chk("R9 no record while err", nrec, 6);
    sc_width = 19;
    @(negedge clk);
    chk("R9 err clears at window 31", int'(cfg_err), 0);
    tick(); pulse_trig(); tick(40);
    pulse_trig(); tick(40);
    chk("R9 budget kept through err", nrec, 8);
    cal_width = 31; cal_delay = 0; sc_width = 0; sc_delay = 31;
    set_mode(12);
    @(negedge clk);
    chk("R9 err on mode above 9", int'(cfg_err), 1);
    tick(); pulse_trig(); tick(40);
    chk("R9 no record with mode 12", nrec, 8);

    // R8 mode write with coincident trigger, then mode 0
    mode_in = 4'd1; mode_wr = 1'b1; trig = 1'b1; tick(); mode_wr = 1'b0; trig = 1'b0;
    tick(5);
    chk("R8 trigger with mode write ignored", nrec, 8);
    pulse_trig();
    wait_start();
    chk("R3 zero width no pulse", sc_ch(0), 300);
    chk("R4 full window pulse", cal_ch(0), 4095);
    tick(40);
    set_mode(4);
    set_mode(0);
    pulse_trig(); tick(40);
    chk("R8 mode 0 disables", nrec, 9);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule